// File: doc/BRIEF.md
# Scaled PN Dither Injector

This block adds a small, controllable pseudo-noise signal to the in-phase and quadrature samples that leave a digital mixer. The noise can deliberately raise the noise floor to lower receiver sensitivity, or it can serve as a wideband test stimulus for checking the response of filters further down the chain. Each noise chip is one bit. It is turned into plus or minus a 16-bit gain word, and that word is placed at fixed bit weights just below the top of the signal word. Three sign bits sit above the gain field, so the injected level can never exceed a quarter of full scale.

There are two maximal-length Fibonacci shift registers, one 15 bits long and one 23 bits long. A select input picks the short code, the long code or the XOR of the two. The quadrature lane gets the same code as the in-phase lane, but taken a fixed number of samples ahead, so the two lanes are decorrelated without a second generator. The noise is added to each lane with saturation, and the result is registered. Both generators advance once for every accepted input sample.

Top module: `pn_dither_injector`

## Requirements
- R1: While reset is asserted, out_i and out_q are zero and out_valid is low. After reset, the short register holds 15'h0001 and the long register holds 23'h000001.
- R2: The short register shifts left once per accepted sample (in_valid high) and loads its LSB with bit14 XOR bit13. Its chip is bit14.
- R3: The long register shifts left once per accepted sample and loads its LSB with bit22 XOR bit17. Its chip is bit22.
- R4: code_sel 2'b00 selects the short chip and 2'b01 selects the long chip. 2'b10 and 2'b11 select the XOR of the two chips. Both registers advance whatever the selection.
- R5: A chip of 1 injects +pn_gain and a chip of 0 injects -pn_gain. The gain LSB has weight 2^-18 of full scale, which is bit DATA_W-19 of the sample, and the injected value is sign-extended to the sample MSB. The magnitude therefore never exceeds (2^16-1)*2^(DATA_W-19).
- R6: With pn_gain zero, each output equals the input sample it belongs to.
- R7: The quadrature chip at sample n equals the in-phase chip at sample n+Q_LEAD (default 7).
- R8: A sum above 2^(DATA_W-1)-1 or below -2^(DATA_W-1) is clamped to that limit instead of wrapping.
- R9: The outputs are registered. They change on the clock edge that accepts a sample, with out_valid high in the following cycle. In a cycle without in_valid, the outputs and both registers hold and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A mixer sample is present this cycle |
| mix_i | input | DATA_W | In-phase mixer sample, signed |
| mix_q | input | DATA_W | Quadrature mixer sample, signed |
| pn_gain | input | 16 | Unsigned noise gain, zero disables injection |
| code_sel | input | 2 | Sequence select: short, long, or combined |
| out_valid | output | 1 | Output samples are new this cycle |
| out_i | output | DATA_W | In-phase sample with noise, signed, saturated |
| out_q | output | DATA_W | Quadrature sample with noise, signed, saturated |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before any sample arrives. They also assume that pn_gain and code_sel are stable in any cycle where in_valid is high, because the bound and direction checks compare each output with the sample and noise sign captured one edge earlier. The bench drives every input on the falling edge, so each value is settled well before the rising edge that samples it. The extreme tests push full-scale positive and negative samples against the largest gain, so that the clamp is actually reached rather than only modelled.

// File: rtl/pn_dither_pkg.sv
package pn_dither_pkg;

  localparam int GAIN_W   = 16;
  localparam int SIGN_EXT = 3;
  localparam int PN_W     = GAIN_W + SIGN_EXT;

  typedef enum logic [1:0] {
    CODE_SHORT = 2'b00,
    CODE_LONG  = 2'b01,
    CODE_XOR   = 2'b10,
    CODE_XOR2  = 2'b11
  } code_sel_e;

  // Map one chip to a signed noise word: 1 -> +gain, 0 -> -gain.
  function automatic logic signed [PN_W-1:0] chip_value(input logic chip,
                                                        input logic [GAIN_W-1:0] g);
    logic signed [PN_W-1:0] mag;
    mag = $signed({{SIGN_EXT{1'b0}}, g});
    return chip ? mag : -mag;
  endfunction

  // Combine the two chips according to the select code.
  function automatic logic pick_chip(input code_sel_e sel, input logic a, input logic b);
    case (sel)
      CODE_SHORT: return a;
      CODE_LONG:  return b;
      default:    return a ^ b;
    endcase
  endfunction

endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int          WIDTH = 15,
  parameter int          TAP_A = 14,
  parameter int          TAP_B = 13,
  parameter int          LEAD  = 7,
  parameter logic [WIDTH-1:0] SEED = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic             chip_now,
  output logic             chip_ahead,
  output logic [WIDTH-1:0] state
);

  localparam int AHEAD_BIT = WIDTH - 1 - LEAD;

  logic [WIDTH-1:0] st;
  logic             feedback;

  assign feedback = st[TAP_A] ^ st[TAP_B];

  always_ff @(posedge clk) begin
    if (!rst_n)    st <= SEED;
    else if (step) st <= {st[WIDTH-2:0], feedback};
  end

  // Shifting left moves future chips toward the MSB, so a lower bit
  // shows the chip that will appear LEAD steps from now.
  assign chip_now   = st[WIDTH-1];
  assign chip_ahead = st[AHEAD_BIT];
  assign state      = st;

endmodule

// File: rtl/pn_code_mux.sv
module pn_code_mux import pn_dither_pkg::*; (
  input  logic [1:0] code_sel,
  input  logic       short_now,
  input  logic       short_ahead,
  input  logic       long_now,
  input  logic       long_ahead,
  output logic       chip_i,
  output logic       chip_q
);

  code_sel_e sel;
  assign sel    = code_sel_e'(code_sel);
  assign chip_i = pick_chip(sel, short_now,   long_now);
  assign chip_q = pick_chip(sel, short_ahead, long_ahead);

endmodule

// File: rtl/pn_lane.sv
module pn_lane import pn_dither_pkg::*; #(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] mix,
  input  logic                     chip,
  input  logic [GAIN_W-1:0]        gain,
  output logic signed [DATA_W-1:0] pn_aligned,
  output logic signed [DATA_W-1:0] out
);

  localparam int SHIFT = DATA_W - PN_W;

  function automatic logic signed [DATA_W-1:0] sat_sum(input logic signed [DATA_W-1:0] a,
                                                       input logic signed [DATA_W-1:0] b);
    logic signed [DATA_W:0] w;
    w = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    if (w[DATA_W] != w[DATA_W-1])
      return w[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    return w[DATA_W-1:0];
  endfunction

  logic signed [PN_W-1:0]   pn_val;
  logic signed [DATA_W-1:0] sum;

  assign pn_val = chip_value(chip, gain);

  generate
    if (SHIFT > 0) begin : g_pad
      assign pn_aligned = {pn_val, {SHIFT{1'b0}}};
    end else begin : g_flush
      assign pn_aligned = pn_val;
    end
  endgenerate

  assign sum = sat_sum(mix, pn_aligned);

  always_ff @(posedge clk) begin
    if (!rst_n)        out <= '0;
    else if (in_valid) out <= sum;
  end

endmodule

// File: rtl/pn_dither_injector.sv
module pn_dither_injector import pn_dither_pkg::*; #(
  parameter int DATA_W = 24,
  parameter int Q_LEAD = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] mix_i,
  input  logic signed [DATA_W-1:0] mix_q,
  input  logic [15:0]              pn_gain,
  input  logic [1:0]               code_sel,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);

  localparam int LANES   = 2;
  localparam int SHORT_W = 15;
  localparam int LONG_W  = 23;

  logic               short_now, short_ahead, long_now, long_ahead;
  logic [SHORT_W-1:0] st_short;
  logic [LONG_W-1:0]  st_long;
  logic               chip_i, chip_q;

  logic signed [DATA_W-1:0] mix_a [LANES];
  logic signed [DATA_W-1:0] out_a [LANES];
  logic signed [DATA_W-1:0] pn_a  [LANES];
  logic                     chip_a[LANES];
  logic signed [DATA_W-1:0] pn_i, pn_q;

  pn_lfsr #(.WIDTH(SHORT_W), .TAP_A(14), .TAP_B(13), .LEAD(Q_LEAD),
            .SEED(15'h0001)) u_short (
    .clk(clk), .rst_n(rst_n), .step(in_valid),
    .chip_now(short_now), .chip_ahead(short_ahead), .state(st_short));

  pn_lfsr #(.WIDTH(LONG_W), .TAP_A(22), .TAP_B(17), .LEAD(Q_LEAD),
            .SEED(23'h000001)) u_long (
    .clk(clk), .rst_n(rst_n), .step(in_valid),
    .chip_now(long_now), .chip_ahead(long_ahead), .state(st_long));

  pn_code_mux u_mux (
    .code_sel(code_sel), .short_now(short_now), .short_ahead(short_ahead),
    .long_now(long_now), .long_ahead(long_ahead),
    .chip_i(chip_i), .chip_q(chip_q));

  assign mix_a[0]  = mix_i;
  assign mix_a[1]  = mix_q;
  assign chip_a[0] = chip_i;
  assign chip_a[1] = chip_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pn_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .mix(mix_a[g]), .chip(chip_a[g]), .gain(pn_gain),
      .pn_aligned(pn_a[g]), .out(out_a[g]));
  end

  assign out_i = out_a[0];
  assign out_q = out_a[1];
  assign pn_i  = pn_a[0];
  assign pn_q  = pn_a[1];

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

endmodule

// File: rtl/pn_dither_checks.sv
module pn_dither_checks #(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] mix_i,
  input logic signed [DATA_W-1:0] mix_q,
  input logic [15:0]              pn_gain,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic signed [DATA_W-1:0] pn_i,
  input logic signed [DATA_W-1:0] pn_q,
  input logic [14:0]              st_short,
  input logic [22:0]              st_long
);

  localparam logic signed [DATA_W+1:0] LIM = (DATA_W+2)'((2**16 - 1) * (2**(DATA_W-19)));

  logic signed [DATA_W-1:0] prev_i, prev_q;
  logic signed [DATA_W+1:0] d_i, d_q;

  always_ff @(posedge clk) begin
    prev_i <= mix_i;
    prev_q <= mix_q;
  end

  assign d_i = {{2{out_i[DATA_W-1]}}, out_i} - {{2{prev_i[DATA_W-1]}}, prev_i};
  assign d_q = {{2{out_q[DATA_W-1]}}, out_q} - {{2{prev_q[DATA_W-1]}}, prev_q};

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_i) && $stable(out_q));

  assert_lfsr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(st_short) && $stable(st_long));

  assert_short_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_short != '0);

  assert_long_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_long != '0);

  assert_gain_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pn_gain == 16'd0 |=> out_i == prev_i && out_q == prev_q);

  assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> d_i <= LIM && d_i >= -LIM && d_q <= LIM && d_q >= -LIM);

  assert_no_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !pn_i[DATA_W-1] |=> out_i >= prev_i);

  assert_no_wrap_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pn_q[DATA_W-1] |=> out_q <= prev_q);

endmodule

bind pn_dither_injector pn_dither_checks #(.DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mix_i(mix_i), .mix_q(mix_q),
  .pn_gain(pn_gain), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
  .pn_i(pn_i), .pn_q(pn_q), .st_short(st_short), .st_long(st_long));

// File: tb/test_pn_dither_injector.sv
module test_pn_dither_injector;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 24;
  localparam int LEAD = 7;
  localparam int UNIT = 1 << (W - 19);
  localparam int VMAX = (1 << (W - 1)) - 1;
  localparam int VMIN = -(1 << (W - 1));
  localparam int NV   = 8;

  // stimulus table: mix_i, mix_q, gain, code select
  localparam int T_MI [NV] = '{0, 1000, -5000, 123456, -800000, 4000000, 77, -1};
  localparam int T_MQ [NV] = '{0, -2000, 3000, -654321, 900000, -4000000, -77, 1};
  localparam int T_G  [NV] = '{1, 100, 65535, 4660, 1, 32768, 65535, 12};
  localparam int T_S  [NV] = '{0, 1, 2, 3, 0, 1, 2, 0};

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] mix_i = '0, mix_q = '0;
  logic [15:0]         pn_gain = '0;
  logic [1:0]          code_sel = '0;
  logic                out_valid;
  logic signed [W-1:0] out_i, out_q;

  int checks = 0;
  int errors = 0;
  logic [14:0] m15;
  logic [22:0] m23;
  int last_i, last_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  pn_dither_injector #(.DATA_W(W), .Q_LEAD(LEAD)) i_pn_dither_injector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mix_i(mix_i), .mix_q(mix_q),
    .pn_gain(pn_gain), .code_sel(code_sel), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q));

  function automatic logic [14:0] nx15(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction
  function automatic logic [22:0] nx23(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction
  function automatic bit sel_chip(input int sel, input logic [14:0] a, input logic [22:0] b);
    if (sel == 0) return a[14];
    if (sel == 1) return b[22];
    return a[14] ^ b[22];
  endfunction
  function automatic int expect_out(input int mi, input bit chip, input int g);
    longint s;
    s = longint'(mi) + longint'(chip ? g : -g) * UNIT;
    if (s > VMAX) s = VMAX;
    if (s < VMIN) s = VMIN;
    return int'(s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One sample: drive, let one rising edge take it, check, advance the model.
  task automatic send(input int mi, input int mq, input int g, input int sel, input string req);
    logic [14:0] a;
    logic [22:0] b;
    bit ci, cq;
    int ei, eq;
    @(negedge clk);
    mix_i = W'(mi); mix_q = W'(mq); pn_gain = 16'(g); code_sel = 2'(sel);
    in_valid = 1'b1;
    ci = sel_chip(sel, m15, m23);
    a = m15; b = m23;
    for (int k = 0; k < LEAD; k++) begin a = nx15(a); b = nx23(b); end
    cq = sel_chip(sel, a, b);
    ei = expect_out(mi, ci, g);
    eq = expect_out(mq, cq, g);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " out_valid"}, int'(out_valid), 1);
    check(int'(out_i) == ei, {req, " out_i"}, int'(out_i), ei);
    check(int'(out_q) == eq, {req, " out_q"}, int'(out_q), eq);
    last_i = int'(out_i); last_q = int'(out_q);
    m15 = nx15(m15); m23 = nx23(m23);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    bit ich[40];
    bit qch[40];
    m15 = 15'h0001; m23 = 23'h000001;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_i == '0, "R1 out_i", int'(out_i), 0);
    check(out_q == '0, "R1 out_q", int'(out_q), 0);
    rst_n = 1'b1;

    // table walk: R1 seed, R2 short, R3 long, R4 select, R5 scaling, R7 lead
    for (int n = 0; n < NV; n++) send(T_MI[n], T_MQ[n], T_G[n], T_S[n], "R4 table");

    // R6: zero gain passes samples through
    send(31415, -27182, 0, 2, "R6 zero gain");
    send(-1, VMAX, 0, 1, "R6 zero gain");

    // R9: idle cycles hold outputs and registers
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 idle valid", int'(out_valid), 0);
    check(int'(out_i) == last_i, "R9 hold out_i", int'(out_i), last_i);
    check(int'(out_q) == last_q, "R9 hold out_q", int'(out_q), last_q);
    send(500, 500, 9, 0, "R9 no advance while idle");

    // R8: saturation at both rails
    for (int n = 0; n < 12; n++) send(VMAX, VMIN, 65535, 2, "R8 clamp");
    for (int n = 0; n < 6; n++) send(VMAX - 100, VMIN + 100, 65535, 1, "R8 clamp near");

    // R2/R3: longer runs on each code
    for (int n = 0; n < 40; n++) send(n * 1000, -n * 1000, 1 + n * 37, n % 4, "R2 R3 run");

    // R7: quadrature chip is in-phase chip LEAD samples later (short code, unit gain)
    for (int n = 0; n < 40; n++) begin
      send(0, 0, 1, 0, "R7 collect");
      ich[n] = (last_i > 0);
      qch[n] = (last_q > 0);
    end
    for (int n = 0; n + LEAD < 40; n++)
      check(qch[n] == ich[n + LEAD], "R7 lead", int'(qch[n]), int'(ich[n + LEAD]));

    // R5: smallest gain moves each lane by exactly one unit
    send(0, 0, 1, 1, "R5 min gain");
    check(last_i == UNIT || last_i == -UNIT, "R5 min step", last_i, UNIT);

    finish_run();
  end

endmodule